// File: doc/BRIEF.md
# Transmit Descriptor Chain Fetcher

This block walks a ring of transmit descriptors held in memory and turns the buffers they point at into frames on a byte stream. Software first stores the address of the first descriptor and then writes a control word with the DMA enable bit set. From then on the block reads descriptors one after another. Each buffer's bytes are appended to a local frame store. When a descriptor marked as the final segment of a frame has been consumed, the stored frame is sent out byte by byte. The walk then moves on to the next descriptor.

Every consumed descriptor is handed back to software. The block clears the ownership bit in the descriptor's status word and writes that word back to memory. The walk stops at the first descriptor that software still holds, or when a frame would grow beyond the frame store. At the end of a walk that sent at least one frame, the block raises a transmit-done flag and clears the start bit of the control word.

Memory is reached through a single request port with a valid/ready handshake. Read data is returned in the same cycle that the request is accepted.

Top module: `txd_chain_dma`

## Requirements
- R1: After reset there is no memory request, no stream output, `walk_busy` and `tx_done` are low, and `ctrl_word` is zero.
- R2: A register write with `reg_sel`=0 while idle sets both the head pointer and the current pointer. A walk reads the descriptor at the head pointer first, as four words at ascending byte addresses base+0 (status), base+4 (size/flags), base+8 (buffer address) and base+12 (next-descriptor address).
- R3: A register write with `reg_sel`=1 while idle stores the word in `ctrl_word`. A walk starts only when bit 30 of the written word is set; without bit 30 the block stays idle.
- R4: A descriptor is consumed only when bit 31 of its status word is 1. The walk ends at the first descriptor whose bit 31 is 0, and that descriptor is not written. A ring whose descriptors were all owned therefore ends after one full turn.
- R5: The byte count of a buffer is bits 10:0 of the size word; bits 31:11 do not affect the count. Buffers start on a word boundary, and bytes are taken from each word lowest byte first.
- R6: After its buffer is copied, a descriptor's status word is written back to its own address with bit 31 cleared and all other bits unchanged. No other descriptor word is written.
- R7: When a descriptor with bit 30 of its size word set has been consumed, the accumulated bytes are sent in memory order, with `out_last` on the final byte, and the accumulator is emptied. A frame with zero accumulated bytes produces no output.
- R8: If the accumulated bytes plus the next buffer's count would exceed MAX_FRAME (2048), the walk stops. That descriptor's status word is written back with bit 14 set and bit 31 kept, and the partial frame is not sent.
- R9: At the end of a walk that sent at least one frame, `tx_done` is set and bit 31 of `ctrl_word` is cleared. Otherwise both keep their values. Starting a walk clears `tx_done`.
- R10: Register writes that arrive while `walk_busy` is high are ignored.
- R11: While `out_valid` is high and `out_ready` is low, the stream holds its data and its last flag. A memory request holds its address and direction until `mem_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = list base, 1 = control word |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid when a read is accepted |
| out_valid | output | 1 | Stream byte valid |
| out_last | output | 1 | Final byte of a frame |
| out_data | output | 8 | Stream byte |
| out_ready | input | 1 | Downstream accepts the byte |
| walk_busy | output | 1 | A descriptor walk is in progress |
| ctrl_word | output | 32 | Current control word |
| tx_done | output | 1 | Transmit-done flag |

## Verification
The hold assertions assume two things about the environment. First, memory returns read data in the accepting cycle. Second, the environment can delay `mem_ready` and `out_ready` arbitrarily. The bench therefore redraws both ready signals at random every cycle and serves reads from a combinational model, so stalls happen in every state.

Descriptor rings are generated with word-aligned buffers and byte counts below the frame limit. The one exception is a directed case that deliberately overflows the frame store. Register writes are issued only between walks, except in the case that checks that writes during a walk are ignored.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_CPRD, S_PUT, S_WB,
    S_LERR, S_EMIT, S_DRAIN, S_NEXT, S_END
  } walk_st_e;

  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 30;
  localparam int LERR_BIT  = 14;
  localparam int START_BIT = 31;
  localparam int EN_BIT    = 30;
  localparam int CNT_W     = 11;
endpackage

// File: rtl/txd_frame_buf.sv
module txd_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txd_byte_out.sv
module txd_byte_out #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  output logic [LW-1:0] rd_idx,
  input  logic [7:0]    rd_byte,
  output logic          out_valid,
  output logic          out_last,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          busy
);
  logic          busy_q, busy_n;
  logic [LW-1:0] idx_q, idx_n, len_q, len_n;

  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx_q == len_q - 1'b1);
  assign out_data  = rd_byte;
  assign rd_idx    = idx_q;
  assign busy      = busy_q;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    len_n  = len_q;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      idx_n  = '0;
      len_n  = len;
    end else if (busy_q && out_ready) begin
      idx_n = idx_q + 1'b1;
      if (out_last) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      len_q  <= len_n;
    end
  end
endmodule

// File: rtl/txd_walk_ctrl.sv
module txd_walk_ctrl
  import txd_pkg::*;
#(
  parameter int MAX_FRAME = 2048,
  parameter int LW        = $clog2(MAX_FRAME + 1),
  parameter int BW        = $clog2(MAX_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          buf_we,
  output logic [BW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          strm_start,
  output logic [LW-1:0] strm_len,
  input  logic          strm_busy,
  output logic          walk_busy,
  output logic [31:0]   ctrl_word,
  output logic          tx_done
);
  walk_st_e         st_q, st_n;
  logic [31:0]      head_q, head_n, cur_q, cur_n, ctrl_q, ctrl_n;
  logic [31:0]      baddr_q, baddr_n, wbuf_q, wbuf_n;
  logic [3:0][31:0] dw_q, dw_n;
  logic [1:0]       widx_q, widx_n, bsel_q, bsel_n;
  logic [LW-1:0]    acc_q, acc_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             done_q, done_n, sent_q, sent_n;
  logic             hs;
  logic [LW:0]      sum;

  assign sum = {1'b0, acc_q} + (LW+1)'(dw_q[1][CNT_W-1:0]);

  // Memory request decode from state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = dw_q[0];
    unique case (st_q)
      S_FETCH: begin mem_req = 1'b1; mem_addr = cur_q + {28'd0, widx_q, 2'b00}; end
      S_CPRD:  begin mem_req = (rem_q != '0); mem_addr = baddr_q; end
      S_WB:    begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata[OWN_BIT] = 1'b0; end
      S_LERR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata[LERR_BIT] = 1'b1; end
      default: ;
    endcase
  end

  assign hs         = mem_req && mem_ready;
  assign buf_we     = (st_q == S_PUT);
  assign buf_waddr  = acc_q[BW-1:0];
  assign buf_wdata  = 8'(wbuf_q >> {bsel_q, 3'b000});
  assign strm_start = (st_q == S_EMIT);
  assign strm_len   = acc_q;
  assign walk_busy  = (st_q != S_IDLE);
  assign ctrl_word  = ctrl_q;
  assign tx_done    = done_q;

  always_comb begin
    st_n = st_q; head_n = head_q; cur_n = cur_q; ctrl_n = ctrl_q;
    baddr_n = baddr_q; wbuf_n = wbuf_q; dw_n = dw_q; widx_n = widx_q;
    bsel_n = bsel_q; acc_n = acc_q; rem_n = rem_q; done_n = done_q; sent_n = sent_q;
    unique case (st_q)
      S_IDLE: if (reg_wr) begin
        if (!reg_sel) begin
          head_n = reg_wdata;
          cur_n  = reg_wdata;
        end else begin
          ctrl_n = reg_wdata;
          if (reg_wdata[EN_BIT]) begin
            cur_n  = head_q;
            done_n = 1'b0;
            sent_n = 1'b0;
            acc_n  = '0;
            widx_n = '0;
            st_n   = S_FETCH;
          end
        end
      end
      S_FETCH: if (hs) begin
        dw_n[widx_q] = mem_rdata;
        widx_n       = widx_q + 1'b1;
        if (widx_q == 2'd3) st_n = S_CHECK;
      end
      S_CHECK: begin
        if (!dw_q[0][OWN_BIT])                   st_n = S_END;
        else if (sum > (LW+1)'(MAX_FRAME))       st_n = S_LERR;
        else begin
          rem_n   = dw_q[1][CNT_W-1:0];
          baddr_n = dw_q[2];
          st_n    = S_CPRD;
        end
      end
      S_CPRD: begin
        if (rem_q == '0) st_n = S_WB;
        else if (hs) begin
          wbuf_n  = mem_rdata;
          bsel_n  = '0;
          baddr_n = baddr_q + 32'd4;
          st_n    = S_PUT;
        end
      end
      S_PUT: begin
        acc_n  = acc_q + 1'b1;
        rem_n  = rem_q - 1'b1;
        bsel_n = bsel_q + 1'b1;
        if (bsel_q == 2'd3 || rem_q == CNT_W'(1)) st_n = S_CPRD;
      end
      S_WB: if (hs) begin
        if (!dw_q[1][LAST_BIT]) st_n = S_NEXT;
        else if (acc_q != '0)   st_n = S_EMIT;
        else                    st_n = S_NEXT;
      end
      S_EMIT:  st_n = S_DRAIN;
      S_DRAIN: if (!strm_busy) begin
        acc_n  = '0;
        sent_n = 1'b1;
        st_n   = S_NEXT;
      end
      S_NEXT: begin
        cur_n  = dw_q[3];
        widx_n = '0;
        st_n   = S_FETCH;
      end
      S_LERR: if (hs) st_n = S_END;
      S_END: begin
        if (sent_q) begin
          done_n            = 1'b1;
          ctrl_n[START_BIT] = 1'b0;
        end
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; head_q <= '0; cur_q <= '0; ctrl_q <= '0;
      baddr_q <= '0; wbuf_q <= '0; dw_q <= '0; widx_q <= '0;
      bsel_q <= '0; acc_q <= '0; rem_q <= '0; done_q <= 1'b0; sent_q <= 1'b0;
    end else begin
      st_q <= st_n; head_q <= head_n; cur_q <= cur_n; ctrl_q <= ctrl_n;
      baddr_q <= baddr_n; wbuf_q <= wbuf_n; dw_q <= dw_n; widx_q <= widx_n;
      bsel_q <= bsel_n; acc_q <= acc_n; rem_q <= rem_n; done_q <= done_n; sent_q <= sent_n;
    end
  end
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma #(
  parameter int MAX_FRAME = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic        out_last,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic        walk_busy,
  output logic [31:0] ctrl_word,
  output logic        tx_done
);
  localparam int LW = $clog2(MAX_FRAME + 1);
  localparam int BW = $clog2(MAX_FRAME);

  logic          buf_we, strm_start, strm_busy;
  logic [BW-1:0] buf_waddr;
  logic [7:0]    buf_wdata, rd_byte;
  logic [LW-1:0] strm_len, rd_idx;

  txd_walk_ctrl #(.MAX_FRAME(MAX_FRAME), .LW(LW), .BW(BW)) u_ctrl (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata,
    .buf_we, .buf_waddr, .buf_wdata,
    .strm_start, .strm_len, .strm_busy,
    .walk_busy, .ctrl_word, .tx_done
  );

  txd_frame_buf #(.DEPTH(MAX_FRAME), .AW(BW)) u_buf (
    .clk, .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(rd_idx[BW-1:0]), .rdata(rd_byte)
  );

  txd_byte_out #(.LW(LW)) u_out (
    .clk, .rst_n, .start(strm_start), .len(strm_len),
    .rd_idx, .rd_byte, .out_valid, .out_last, .out_data, .out_ready,
    .busy(strm_busy)
  );
endmodule

// File: rtl/txd_chain_dma_chk.sv
module txd_chain_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        out_valid,
  input logic        out_last,
  input logic [7:0]  out_data,
  input logic        out_ready,
  input logic        walk_busy,
  input logic [31:0] ctrl_word,
  input logic        tx_done
);
  // R11
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  wb_no_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_wdata[14] |-> !mem_wdata[31]);

  // R9
  done_clears_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !ctrl_word[31] && !walk_busy);

  // R7
  stream_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> walk_busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_busy |-> !mem_req && !out_valid);
endmodule

bind txd_chain_dma txd_chain_dma_chk u_chk (.*);

// File: tb/txd_chain_dma_bench.sv
module txd_chain_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_last, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        walk_busy, tx_done;
  logic [31:0] ctrl_word;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [4096];
  logic [31:0] refm [4096];
  logic [8:0]  got [$];
  logic [8:0]  expq [$];
  int          exp_sent;
  logic        cap_first = 1'b0;
  logic [31:0] first_addr;

  always #5 clk = ~clk;

  txd_chain_dma u_txd_chain_dma (.*);

  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk)
    if (mem_req && mem_ready && mem_we) mem[mem_addr[13:2]] <= mem_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = ($urandom % 4) != 0;
      mem_ready = ($urandom % 3) != 0;
    end
    #1;
    if (out_valid && out_ready) got.push_back({out_last, out_data});
    if (cap_first && mem_req) begin first_addr = mem_addr; cap_first = 1'b0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  task automatic put_desc(input int a, input bit own, input int len, input bit last,
                          input int ba, input int nx);
    mem[a/4]     = {own, 16'($urandom), 1'b0, 14'($urandom)} & 32'hFFFF_BFFF;
    mem[a/4 + 1] = {1'b0, last, 19'($urandom), 11'(len)};
    mem[a/4 + 2] = 32'(ba);
    mem[a/4 + 3] = 32'(nx);
    for (int i = 0; i < (len + 3) / 4; i++) mem[ba/4 + i] = $urandom;
  endtask

  // Reference walk computed from the requirements on a copy of memory
  function automatic void model(input int head);
    int cur = head;
    logic [7:0] acc [$];
    expq.delete(); exp_sent = 0;
    for (int i = 0; i < 4096; i++) refm[i] = mem[i];
    for (int guard = 0; guard < 200; guard++) begin
      logic [31:0] s, z, b;
      s = refm[cur/4]; z = refm[cur/4 + 1]; b = refm[cur/4 + 2];
      if (!s[31]) break;
      if (acc.size() + int'(z[10:0]) > 2048) begin
        refm[cur/4] = s | 32'h4000;
        break;
      end
      for (int k = 0; k < int'(z[10:0]); k++) begin
        logic [31:0] w;
        w = refm[(int'(b) + k) / 4];
        acc.push_back(8'(w >> (8 * (k % 4))));
      end
      refm[cur/4] = s & 32'h7FFF_FFFF;
      if (z[30]) begin
        if (acc.size() > 0) begin
          for (int k = 0; k < acc.size(); k++)
            expq.push_back({k == acc.size() - 1, acc[k]});
          exp_sent++;
        end
        acc.delete();
      end
      cur = int'(refm[cur/4 + 3]);
    end
  endfunction

  task automatic run_walk(input string tag, input int head, input logic [31:0] cw);
    int bad = 0;
    logic [31:0] exp_ctrl;
    model(head);
    got.delete();
    cap_first = 1'b1;
    reg_write(1'b1, cw);
    while (walk_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check({tag, " R2 first fetch"}, first_addr, 32'(head));
    check({tag, " R7 byte count"}, got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      if (got[i] !== expq[i]) bad++;
    check({tag, " R5 R7 stream bytes"}, bad, 0);
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== refm[i]) bad++;
    check({tag, " R6 R8 writeback"}, bad, 0);
    check({tag, " R9 done"}, tx_done, exp_sent > 0);
    exp_ctrl = cw;
    if (exp_sent > 0) exp_ctrl[31] = 1'b0;
    check({tag, " R9 ctrl"}, ctrl_word, exp_ctrl);
  endtask

  initial begin
    void'($urandom(32'd1234));
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", walk_busy, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 tx_done", tx_done, 0);
    check("R1 ctrl_word", ctrl_word, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: control write without enable bit does not start
    reg_write(1'b1, 32'h8000_1234);
    repeat (3) @(negedge clk);
    check("R3 no start", walk_busy, 0);
    check("R3 stored", ctrl_word, 32'h8000_1234);

    // Directed: two-segment frame, single frame, empty frame, unowned stop (R4 R5 R7)
    clear_mem();
    put_desc(32'h100, 1, 5, 0, 32'h1000, 32'h110);
    put_desc(32'h110, 1, 7, 1, 32'h1100, 32'h120);
    put_desc(32'h120, 1, 3, 1, 32'h1200, 32'h130);
    put_desc(32'h130, 1, 0, 1, 32'h1300, 32'h140);
    put_desc(32'h140, 0, 9, 1, 32'h1400, 32'h100);
    reg_write(1'b0, 32'h100);
    run_walk("directed", 32'h100, 32'hC000_0000);
    check("R7 frames sent", exp_sent, 2);

    // R9: new walk with nothing owned clears done, keeps start bit
    run_walk("none_owned", 32'h100, 32'hC000_0005);
    check("R4 R9 no frames", tx_done, 0);

    // R4: full ring of owned descriptors ends after one turn
    clear_mem();
    for (int i = 0; i < 4; i++)
      put_desc(32'h200 + 16*i, 1, 10 + i, 1, 32'h1000 + 32'h100*i, 32'h200 + 16*((i+1)%4));
    reg_write(1'b0, 32'h200);
    run_walk("ring", 32'h200, 32'hC000_0000);
    check("R4 ring frames", exp_sent, 4);

    // R8: length error
    clear_mem();
    put_desc(32'h000, 1, 1500, 0, 32'h1000, 32'h010);
    put_desc(32'h010, 1, 1000, 1, 32'h2000, 32'h000);
    reg_write(1'b0, 32'h000);
    run_walk("lenerr", 32'h000, 32'hC000_0000);
    check("R8 status bits", mem[4] & 32'h8000_4000, 32'h8000_4000);

    // R10: writes during a walk are ignored
    clear_mem();
    put_desc(32'h300, 1, 200, 1, 32'h1000, 32'h310);
    put_desc(32'h310, 1, 200, 1, 32'h1100, 32'h300);
    reg_write(1'b0, 32'h300);
    got.delete();
    reg_write(1'b1, 32'hC000_00AA);
    reg_write(1'b0, 32'h500);
    reg_write(1'b1, 32'h4000_0055);
    while (walk_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R10 ctrl kept", ctrl_word, 32'h4000_00AA);
    check("R10 bytes", got.size(), 400);
    run_walk("r10_head", 32'h300, 32'hC000_0000);

    // Random rings (R5 R7)
    for (int it = 0; it < 12; it++) begin
      int n = 2 + ($urandom % 7);
      clear_mem();
      for (int i = 0; i < n; i++)
        put_desc(32'h100 + 16*i, (i == 0) || (($urandom % 7) != 0), $urandom % 121,
                 (i == n-1) || ($urandom % 2), 32'h1000 + 32'h100*i, 32'h100 + 16*((i+1)%n));
      reg_write(1'b0, 32'h100);
      run_walk($sformatf("rand%0d", it), 32'h100, 32'hC000_0000 | ($urandom & 32'hFFFF));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule